// File: doc/BRIEF.md
# Cascaded DMA Request Mask Unit

This block keeps the request-mask state for two four-channel DMA controllers wired in cascade: a lower controller owning channels 0 to 3 and an upper controller owning channels 4 to 7. The lower controller reaches the bus through channel 4 of the upper one. Software changes the masks through I/O writes. Each controller has two write paths. The group-mask port replaces all four bits at once. The single-mask port changes one bit. A read of the group-mask port returns the current mask status.

Hardware also moves the masks. When a channel reports terminal count, its bit sets by itself, unless that channel runs in auto-initialization mode. A master clear for a controller, or reset, sets all four bits of that controller. The raw DMA request lines leave the block gated by their mask bits. Channel 4's mask also gates all four lower channels, because they share its cascade path. Terminal-count and auto-init indications come in as inputs. Address and count registers, arbitration and transfer sequencing are kept in other blocks.

Top module: `dma_req_mask_unit`

## Requirements
- R1: After reset, all eight mask bits are 1. A read of either group-mask port returns 8'h0F, and every gated request is 0.
- R2: A write to the group-mask port (lower controller at 16'h000F, upper at 16'h00DE) loads data bits 3:0 into that controller's four mask bits in the next cycle. Bit n holds local channel n, and 1 means masked. The other controller is unchanged.
- R3: A read of a group-mask port returns the controller's mask bits in data bits 3:0 and 0 in bits 7:4. Data bits 7:4 of a group-mask write are ignored.
- R4: A write to the single-mask port (lower at 16'h000A, upper at 16'h00D4) uses data bits 1:0 as the local channel number and data bit 2 as the new mask value for that channel. The other three bits stay as they were.
- R5: A cycle with terminal count asserted on a channel sets that channel's mask bit to 1 in the next cycle, unless that channel's auto-init input is high. With auto-init high, the bit is unchanged.
- R6: If a terminal-count set and a register write that clears the same bit fall in the same cycle, the bit ends at 1.
- R7: A master-clear pulse for a controller (mclr bit 0 lower, bit 1 upper) sets all four of its mask bits in the next cycle and leaves the other controller alone.
- R8: Each gated request equals its raw request ANDed with the inverse of its own mask bit. The gating is combinational from the registered masks.
- R9: While channel 4 is masked, gated requests for channels 0 to 3 are all 0, whatever their own mask bits are.
- R10: A write to any other address changes no mask bit. A read of any other address returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| mclr | input | 2 | Master clear per controller |
| tc | input | 8 | Terminal count per channel |
| autoinit | input | 8 | Auto-init mode per channel |
| dreq_raw | input | 8 | Raw DMA requests |
| dreq_gated | output | 8 | Requests after mask and cascade gating |

## Verification
A wrong mask bit appears on the same-cycle gated request of that channel and on the next read of its group-mask port. Each write or terminal-count event can therefore be checked one cycle later.

Some faults show up only in particular states:
- A fault in the cascade term is visible only while channel 4 is masked and a lower channel is requesting.
- A priority fault between terminal count and a write shows only when both land in the same cycle.

The bench arranges each of these states on purpose.

// File: rtl/dmamask_pkg.sv
package dmamask_pkg;
  localparam int CH_PER_CTRL = 4;
  localparam int N_CTRL      = 2;
  localparam int SEL_W       = $clog2(CH_PER_CTRL);
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 16;

  typedef logic [CH_PER_CTRL-1:0] chmask_t;

  // Single-bit update: data[SEL_W-1:0] picks the channel, data[SEL_W] is the value.
  function automatic chmask_t single_update(chmask_t cur, logic [DATA_W-1:0] d);
    chmask_t r;
    r = cur;
    r[d[SEL_W-1:0]] = d[SEL_W];
    return r;
  endfunction

  // Channels that self-mask this cycle.
  function automatic chmask_t tc_autoset(chmask_t tcv, chmask_t ai);
    return tcv & ~ai;
  endfunction

  // Request gating for one controller, with an extra block term.
  function automatic chmask_t gate_req(chmask_t raw, chmask_t m, logic blocked);
    return blocked ? '0 : (raw & ~m);
  endfunction

  // Read data formed from a mask, reserved bits zero.
  function automatic logic [DATA_W-1:0] status_byte(chmask_t m);
    logic [DATA_W-1:0] r;
    r = '0;
    r[CH_PER_CTRL-1:0] = m;
    return r;
  endfunction
endpackage

// File: rtl/dm_port_decode.sv
module dm_port_decode
  import dmamask_pkg::*;
#(
  parameter logic [ADDR_W-1:0] GRP_PORT_LO = 16'h000F,
  parameter logic [ADDR_W-1:0] GRP_PORT_HI = 16'h00DE,
  parameter logic [ADDR_W-1:0] ONE_PORT_LO = 16'h000A,
  parameter logic [ADDR_W-1:0] ONE_PORT_HI = 16'h00D4
) (
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  output logic [N_CTRL-1:0] wr_grp,
  output logic [N_CTRL-1:0] wr_one,
  output logic [N_CTRL-1:0] rd_grp
);
  logic [N_CTRL-1:0] hit_grp, hit_one;

  always_comb begin
    hit_grp[0] = (io_addr == GRP_PORT_LO);
    hit_grp[1] = (io_addr == GRP_PORT_HI);
    hit_one[0] = (io_addr == ONE_PORT_LO);
    hit_one[1] = (io_addr == ONE_PORT_HI);
  end

  assign wr_grp = hit_grp & {N_CTRL{io_wr}};
  assign wr_one = hit_one & {N_CTRL{io_wr}};
  assign rd_grp = hit_grp & {N_CTRL{io_rd}};
endmodule

// File: rtl/dm_mask_bank.sv
module dm_mask_bank
  import dmamask_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              wr_grp,
  input  logic              wr_one,
  input  logic [DATA_W-1:0] wdata,
  input  chmask_t           tc,
  input  chmask_t           autoinit,
  output chmask_t           mask
);
  chmask_t mask_q, sw_next, tc_set, mask_d;

  assign tc_set = tc_autoset(tc, autoinit);

  always_comb begin
    sw_next = mask_q;
    if (wr_grp)      sw_next = wdata[CH_PER_CTRL-1:0];
    else if (wr_one) sw_next = single_update(mask_q, wdata);
    // Terminal-count set wins over any software clear.
    mask_d = mclr ? '1 : (sw_next | tc_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  assign mask = mask_q;

  // R5 R6
  tc_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_set) |=> ((mask_q & $past(tc_set)) == $past(tc_set)));

  // R7
  mclr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask_q == '1));

  // R2
  grp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grp && !mclr && tc_set == '0) |=> (mask_q == $past(wdata[CH_PER_CTRL-1:0])));

  // R4
  one_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_one && !mclr && tc_set == '0) |=>
      (((mask_q ^ $past(mask_q)) & ~(chmask_t'(1) << $past(wdata[SEL_W-1:0]))) == '0));

  // R4
  one_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_one && !mclr && tc_set == '0) |=>
      (mask_q[$past(wdata[SEL_W-1:0])] == $past(wdata[SEL_W])));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_grp && !wr_one && !mclr && tc_set == '0) |=> $stable(mask_q));
endmodule

// File: rtl/dm_req_gate.sv
module dm_req_gate
  import dmamask_pkg::*;
#(
  parameter int CASC_CH = 0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_CTRL*CH_PER_CTRL-1:0]   raw,
  input  chmask_t                         mask_lo,
  input  chmask_t                         mask_hi,
  output logic [N_CTRL*CH_PER_CTRL-1:0]   gated
);
  logic    casc_blocked;
  chmask_t gated_lo, gated_hi;

  assign casc_blocked = mask_hi[CASC_CH];
  assign gated_lo = gate_req(raw[CH_PER_CTRL-1:0], mask_lo, casc_blocked);
  assign gated_hi = gate_req(raw[N_CTRL*CH_PER_CTRL-1:CH_PER_CTRL], mask_hi, 1'b0);
  assign gated = {gated_hi, gated_lo};

  // R9
  casc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_hi[CASC_CH] |-> (gated[CH_PER_CTRL-1:0] == '0));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated & {mask_hi, mask_lo}) == '0);

  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated & ~raw) == '0);
endmodule

// File: rtl/dma_req_mask_unit.sv
module dma_req_mask_unit
  import dmamask_pkg::*;
#(
  parameter logic [ADDR_W-1:0] GRP_PORT_LO = 16'h000F,
  parameter logic [ADDR_W-1:0] GRP_PORT_HI = 16'h00DE,
  parameter logic [ADDR_W-1:0] ONE_PORT_LO = 16'h000A,
  parameter logic [ADDR_W-1:0] ONE_PORT_HI = 16'h00D4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          io_wr,
  input  logic                          io_rd,
  input  logic [ADDR_W-1:0]             io_addr,
  input  logic [DATA_W-1:0]             io_wdata,
  output logic [DATA_W-1:0]             io_rdata,
  input  logic [N_CTRL-1:0]             mclr,
  input  logic [N_CTRL*CH_PER_CTRL-1:0] tc,
  input  logic [N_CTRL*CH_PER_CTRL-1:0] autoinit,
  input  logic [N_CTRL*CH_PER_CTRL-1:0] dreq_raw,
  output logic [N_CTRL*CH_PER_CTRL-1:0] dreq_gated
);
  logic [N_CTRL-1:0] wr_grp, wr_one, rd_grp;
  chmask_t           mask [N_CTRL];

  dm_port_decode #(
    .GRP_PORT_LO(GRP_PORT_LO), .GRP_PORT_HI(GRP_PORT_HI),
    .ONE_PORT_LO(ONE_PORT_LO), .ONE_PORT_HI(ONE_PORT_HI)
  ) u_dec (
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .wr_grp(wr_grp), .wr_one(wr_one), .rd_grp(rd_grp)
  );

  for (genvar c = 0; c < N_CTRL; c++) begin : g_bank
    dm_mask_bank u_bank (
      .clk(clk), .rst_n(rst_n), .mclr(mclr[c]),
      .wr_grp(wr_grp[c]), .wr_one(wr_one[c]), .wdata(io_wdata),
      .tc(tc[c*CH_PER_CTRL +: CH_PER_CTRL]),
      .autoinit(autoinit[c*CH_PER_CTRL +: CH_PER_CTRL]),
      .mask(mask[c])
    );
  end

  always_comb begin
    io_rdata = '0;
    for (int c = 0; c < N_CTRL; c++)
      if (rd_grp[c]) io_rdata = status_byte(mask[c]);
  end

  dm_req_gate #(.CASC_CH(0)) u_gate (
    .clk(clk), .rst_n(rst_n), .raw(dreq_raw),
    .mask_lo(mask[0]), .mask_hi(mask[1]), .gated(dreq_gated)
  );

  // R3
  rdata_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[DATA_W-1:CH_PER_CTRL] == '0);

  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grp == '0) |-> (io_rdata == '0));
endmodule

// File: tb/dma_req_mask_unit_bench.sv
module dma_req_mask_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic [1:0]  mclr = '0;
  logic [7:0]  tc = '0, autoinit = '0, dreq_raw = '0, dreq_gated;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_req_mask_unit u_dma_req_mask_unit (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mclr(mclr), .tc(tc),
    .autoinit(autoinit), .dreq_raw(dreq_raw), .dreq_gated(dreq_gated)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0; io_addr = '0; io_wdata = '0;
  endtask

  task automatic rd_check(string req, logic [15:0] a, logic [7:0] exp);
    @(negedge clk); io_rd = 1; io_addr = a; #1;
    check(req, io_rdata, exp);
    io_rd = 0; io_addr = '0;
  endtask

  task automatic t_reset();
    dreq_raw = 8'hFF; #1;
    check("R1 gated", dreq_gated, 8'h00);
    rd_check("R1 lo", 16'h000F, 8'h0F);
    rd_check("R1 hi", 16'h00DE, 8'h0F);
  endtask

  task automatic t_group();
    wr(16'h000F, 8'h05);
    rd_check("R2 lo load", 16'h000F, 8'h05);
    rd_check("R2 hi untouched", 16'h00DE, 8'h0F);
    wr(16'h00DE, 8'hF2);
    rd_check("R3 reserved ignored", 16'h00DE, 8'h02);
  endtask

  task automatic t_gate();
    dreq_raw = 8'hFF; #1;
    check("R8 gating", dreq_gated, 8'hDA);
    wr(16'h00DE, 8'h01); #1;
    check("R9 cascade block", dreq_gated, 8'hE0);
    dreq_raw = 8'h0C; #1;
    check("R9 cascade block pattern", dreq_gated, 8'h00);
  endtask

  task automatic t_single();
    wr(16'h000A, 8'h05);
    rd_check("R4 set ch1", 16'h000F, 8'h07);
    wr(16'h000A, 8'h00);
    rd_check("R4 clear ch0", 16'h000F, 8'h06);
    wr(16'h00D4, 8'h07);
    rd_check("R4 set ch7", 16'h00DE, 8'h09);
  endtask

  task automatic t_tc();
    wr(16'h000F, 8'h00);
    @(negedge clk); tc = 8'h03; autoinit = 8'h02;
    @(negedge clk); tc = '0; autoinit = '0;
    rd_check("R5 tc autoset", 16'h000F, 8'h01);
  endtask

  task automatic t_tc_vs_write();
    @(negedge clk); io_wr = 1; io_addr = 16'h000F; io_wdata = 8'h00; tc = 8'h04;
    @(negedge clk); io_wr = 0; io_addr = '0; tc = '0;
    rd_check("R6 tc wins", 16'h000F, 8'h04);
  endtask

  task automatic t_mclr();
    @(negedge clk); mclr = 2'b10;
    @(negedge clk); mclr = 2'b00;
    rd_check("R7 hi cleared", 16'h00DE, 8'h0F);
    rd_check("R7 lo untouched", 16'h000F, 8'h04);
  endtask

  task automatic t_unmapped();
    wr(16'h000E, 8'h00);
    wr(16'h010F, 8'h00);
    rd_check("R10 no write", 16'h000F, 8'h04);
    rd_check("R10 read zero", 16'h000E, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_group();
    t_gate();
    t_single();
    t_tc();
    t_tc_vs_write();
    t_mclr();
    t_unmapped();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule